// File: doc/BRIEF.md
# Lane Inactivity Counter Controller

This block tracks divergent control flow for a group of SIMD lanes. It does not keep a stack of masks. Each lane has a small saturating-free counter that records how many enclosing conditional levels have switched it off, and a lane is enabled exactly when its counter reads zero. The sequencer sends one structured-branch command per cycle: open a conditional with a per-lane predicate, flip to the alternate branch, or close the conditional. All lane counters update together in a single cycle.

Commands arrive on a valid/ready port. `cmd_ready` is low while reset is asserted and stays high from the first clock after reset, so a command is taken on every edge where `cmd_valid` is high. The producer may hold `cmd_valid` low for any number of cycles. There is no back-pressure beyond reset, and no command is ever held inside the block. The enable mask and the two error pulses are registered. They reflect a command in the cycle after it is accepted.

Nesting depth is limited by the counter range, set by `MAX_DEPTH`. A command that would push a counter past that range, or that would close a conditional when none is open, is dropped whole and reported on a one-cycle flag.

Top module: `actr_ctrl`

## Requirements
- R1: While reset is asserted, all counters are zero, `active_mask` is all ones, both error flags are low and `cmd_ready` is low.
- R2: Opcode 2'b00 opens a conditional, using `cmd_cond` bit i for lane i. A lane with counter 0 and condition 1 keeps counter 0. A lane with counter 0 and condition 0 goes to 1. Every lane with a nonzero counter increments, whatever its condition bit.
- R3: If an open-conditional command would raise any counter above `MAX_DEPTH`, no counter changes and `overflow` is high for one cycle.
- R4: Opcode 2'b01 switches to the alternate branch. A counter of 0 becomes 1, a counter of 1 becomes 0, and counters of 2 or more are unchanged.
- R5: Opcode 2'b10 closes a conditional. Every nonzero counter decrements by one.
- R6: A close command when every counter is zero changes nothing and raises `underflow` for one cycle.
- R7: `active_mask` bit i is 1 exactly when lane i's counter is 0. It is a register and shows the result of a command in the cycle after that command is accepted.
- R8: Opcode 2'b11 and cycles with `cmd_valid` low change no counter and raise no flag.
- R9: After reset, `cmd_ready` is high on every cycle, and back-to-back commands are each applied in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high together with valid |
| cmd_op | input | 2 | 00 open, 01 alternate, 10 close, 11 reserved |
| cmd_cond | input | LANES | Per-lane predicate for the open command |
| active_mask | output | LANES | Bit i high when lane i is enabled |
| overflow | output | 1 | One-cycle pulse: open command dropped for depth |
| underflow | output | 1 | One-cycle pulse: close command with nothing open |

## Verification
The bench goes after three kinds of corner case. The first is the alternate command on lanes that are two or more levels deep. A design that flipped every counter there would re-enable lanes an outer branch had disabled. The second is driving a lane to the depth limit and then opening once more. A design that wrapped or partly applied the command would leave lanes enabled out of turn after the matching closes. The third is a close issued with nothing open, along with reserved opcodes and held-off valid. A design that decremented or wrapped in these cases would lose mask state or show spurious flags, and the mask would then disagree with the bench's own counter model.

// File: rtl/actr_pkg.sv
package actr_pkg;
  typedef enum logic [1:0] {
    OP_OPEN = 2'b00,
    OP_ALT  = 2'b01,
    OP_CLOSE = 2'b10,
    OP_RSVD = 2'b11
  } actr_op_e;

  function automatic int unsigned cnt_width(input int unsigned max_depth);
    return (max_depth < 1) ? 1 : $clog2(max_depth + 1);
  endfunction
endpackage

// File: rtl/actr_lane.sv
module actr_lane
  import actr_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 3,
  localparam int unsigned CW = cnt_width(MAX_DEPTH)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     commit,
  input  actr_op_e op,
  input  logic     cond,
  output logic     mask_o,
  output logic     at_max_o,
  output logic     nonzero_o
);
  localparam logic [CW-1:0] CMAX = CW'(MAX_DEPTH);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          mask_q;

  always_comb begin
    cnt_nxt = cnt_q;
    unique case (op)
      OP_OPEN:  if (!(cnt_q == '0 && cond)) cnt_nxt = cnt_q + ONE;
      OP_ALT: begin
        if (cnt_q == '0)       cnt_nxt = ONE;
        else if (cnt_q == ONE) cnt_nxt = '0;
      end
      OP_CLOSE: if (cnt_q != '0) cnt_nxt = cnt_q - ONE;
      default:  cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      mask_q <= 1'b1;
    end else if (commit) begin
      cnt_q  <= cnt_nxt;
      mask_q <= (cnt_nxt == '0);
    end
  end

  assign mask_o    = mask_q;
  assign at_max_o  = (cnt_q == CMAX);
  assign nonzero_o = (cnt_q != '0);

  p_mask_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q == (cnt_q == '0));
  p_open_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == OP_OPEN && cnt_q == '0 && cond |=> cnt_q == '0);
  p_open_deeper_r2: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == OP_OPEN && cnt_q != '0 |=> cnt_q == $past(cnt_q) + ONE);
  p_alt_swap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == OP_ALT && cnt_q == '0 |=> cnt_q == ONE);
  p_alt_deep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == OP_ALT && cnt_q > ONE |=> $stable(cnt_q));
  p_close_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit && op == OP_CLOSE && cnt_q != '0 |=> cnt_q == $past(cnt_q) - ONE);
endmodule

// File: rtl/actr_guard.sv
module actr_guard
  import actr_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  actr_op_e         op,
  input  logic [LANES-1:0] at_max,
  input  logic [LANES-1:0] nonzero,
  output logic             commit,
  output logic             ovf_o,
  output logic             unf_o
);
  logic ovf_c, unf_c, ovf_q, unf_q;

  assign ovf_c  = fire && (op == OP_OPEN)  && (|at_max);
  assign unf_c  = fire && (op == OP_CLOSE) && !(|nonzero);
  assign commit = fire && (op != OP_RSVD) && !ovf_c && !unf_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_c;
      unf_q <= unf_c;
    end
  end

  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_q && unf_q));
  p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !ovf_q && !unf_q);
endmodule

// File: rtl/actr_ctrl.sv
module actr_ctrl
  import actr_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned MAX_DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  input  logic [LANES-1:0] cmd_cond,
  output logic [LANES-1:0] active_mask,
  output logic             overflow,
  output logic             underflow
);
  actr_op_e         op;
  logic             rdy_q, fire, commit;
  logic [LANES-1:0] at_max, nonzero, mask;

  assign op = actr_op_e'(cmd_op);

  always_ff @(posedge clk) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign cmd_ready = rdy_q;
  assign fire      = cmd_valid && rdy_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    actr_lane #(.MAX_DEPTH(MAX_DEPTH)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .op       (op),
      .cond     (cmd_cond[g]),
      .mask_o   (mask[g]),
      .at_max_o (at_max[g]),
      .nonzero_o(nonzero[g])
    );
  end

  actr_guard #(.LANES(LANES)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .op     (op),
    .at_max (at_max),
    .nonzero(nonzero),
    .commit (commit),
    .ovf_o  (overflow),
    .unf_o  (underflow)
  );

  assign active_mask = mask;

  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> active_mask == $past(active_mask));
  p_unf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> active_mask == $past(active_mask));
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(active_mask));
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cmd_ready);
endmodule

// File: tb/actr_ctrl_test.sv
`timescale 1ns/1ps
module actr_ctrl_test;
  localparam int LANES = 4;
  localparam int MAXD  = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [1:0]       cmd_op = 2'b00;
  logic [LANES-1:0] cmd_cond = '0;
  logic [LANES-1:0] active_mask;
  logic             overflow, underflow;

  actr_ctrl #(.LANES(LANES), .MAX_DEPTH(MAXD)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_cond(cmd_cond), .active_mask(active_mask),
    .overflow(overflow), .underflow(underflow));

  int mdl [LANES];
  int vectors = 0;
  int errors  = 0;
  bit fired   = 1'b0;
  bit finished = 1'b0;
  logic [LANES+1:0] exp_q [$];
  string            req_q [$];

  function automatic logic [LANES-1:0] mdl_mask();
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (mdl[i] == 0);
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [LANES-1:0] cond, string req);
    int nx [LANES];
    bit ovf = 1'b0, unf = 1'b0, anynz = 1'b0;
    for (int i = 0; i < LANES; i++) nx[i] = mdl[i];
    case (op)
      2'b00: for (int i = 0; i < LANES; i++)
        if (!(mdl[i] == 0 && cond[i])) begin
          if (mdl[i] == MAXD) ovf = 1'b1;
          nx[i] = mdl[i] + 1;
        end
      2'b01: for (int i = 0; i < LANES; i++)
        if (mdl[i] == 0) nx[i] = 1; else if (mdl[i] == 1) nx[i] = 0;
      2'b10: begin
        for (int i = 0; i < LANES; i++) if (mdl[i] != 0) anynz = 1'b1;
        if (!anynz) unf = 1'b1;
        else for (int i = 0; i < LANES; i++) if (mdl[i] != 0) nx[i] = mdl[i] - 1;
      end
      default: ;
    endcase
    if (!ovf && !unf) for (int i = 0; i < LANES; i++) mdl[i] = nx[i];
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_cond  = cond;
    exp_q.push_back({ovf, unf, mdl_mask()});
    req_q.push_back(req);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
    end
  endtask

  // monitor: pop the expected item for each accepted command
  always @(posedge clk) fired <= rst_n && cmd_valid && cmd_ready;

  always @(negedge clk) begin
    if (fired) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: actual result with no command expected 0");
      end else begin
        logic [LANES+1:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(r, {30'(0), overflow, underflow} << LANES | 32'(active_mask), 32'(e));
      end
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LANES; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    check("R1 mask", 32'(active_mask), 32'hF);
    check("R1 flags", {30'(0), overflow, underflow}, 0);
    check("R1 ready", 32'(cmd_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready", 32'(cmd_ready), 1);

    // nested open / alternate / close, back-to-back (R2 R4 R5 R7 R9)
    send(2'b00, 4'b0011, "R2 outer open");
    send(2'b00, 4'b0001, "R2 inner open");
    send(2'b01, 4'b0000, "R4 inner alternate");
    send(2'b10, 4'b0000, "R5 inner close");
    send(2'b10, 4'b0000, "R5 outer close");
    // close with nothing open (R6)
    send(2'b10, 4'b1111, "R6 underflow");
    send(2'b00, 4'b1111, "R2 all-true open");
    send(2'b10, 4'b0000, "R5 close after R6");
    idle(2);

    // alternate leaves deep counters alone (R4)
    send(2'b00, 4'b0101, "R2 open 0101");
    send(2'b00, 4'b0000, "R2 open all false");
    send(2'b01, 4'b1111, "R4 alternate deep");
    send(2'b11, 4'b0000, "R8 reserved op");
    send(2'b10, 4'b0000, "R5 close");
    send(2'b10, 4'b0000, "R5 close");
    send(2'b10, 4'b0000, "R6 underflow again");
    idle(2);

    // depth limit (R3)
    send(2'b00, 4'b0000, "R3 depth 1");
    send(2'b00, 4'b1111, "R3 depth 2");
    send(2'b00, 4'b0000, "R3 depth 3");
    send(2'b00, 4'b0000, "R3 overflow");
    send(2'b01, 4'b0000, "R4 alternate at depth");
    send(2'b10, 4'b0000, "R3 close 1");
    send(2'b10, 4'b0000, "R3 close 2");
    send(2'b10, 4'b0000, "R3 close 3");
    idle(2);

    // valid low must not act (R8)
    send(2'b00, 4'b1010, "R2 open 1010");
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_op    = 2'b00;
    cmd_cond  = 4'b0000;
    @(negedge clk);
    @(negedge clk);
    check("R8 idle mask", 32'(active_mask), 32'(mdl_mask()));
    check("R8 idle flags", {30'(0), overflow, underflow}, 0);
    send(2'b10, 4'b0000, "R5 final close");
    idle(3);
    check("R7 final mask", 32'(active_mask), 32'hF);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule